// File: doc/BRIEF.md
# Integer ALU with Overflow Detection

This block is a 32-bit integer arithmetic unit for an execution pipeline. It adds and subtracts in two's complement, performs signed and unsigned set-less-than, and builds an upper-immediate constant whose low half is zero. A single shared adder does all of the arithmetic. Subtraction inverts the second operand and feeds a carry-in of one. Signed overflow is the carry into the sign bit XOR the carry out of it.

Requests arrive on a valid/ready stream: operands, immediate and operation select travel together. Each accepted request produces exactly one registered response. The output stage holds one entry. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A response stays valid and unchanged until it is taken by `out_valid && out_ready`. Requests are never dropped or reordered.

Top module: `int_alu`

## Requirements
- R1: Add (op 3'b000) returns a+b modulo 2^32. `cout_flag` is the carry out of bit 31, and that carry does not appear in the result. Example: all-ones plus all-ones gives 32'hFFFFFFFE with carry 1 and overflow 0.
- R2: Subtract (op 3'b001) returns a + ~b + 1 modulo 2^32. `cout_flag` is the carry out of bit 31 of that sum.
- R3: `ovf_flag` is 1 for add and subtract exactly when the operand signs agree (add) or differ (subtract) and the result sign differs from a's sign. It is 0 for every other operation.
- R4: Signed less-than (op 3'b010) returns 32'd1 when a < b as signed numbers and 32'd0 otherwise, including when a-b overflows. Both flags are 0.
- R5: Unsigned less-than (op 3'b011) returns 32'd1 when a < b as unsigned numbers and 32'd0 otherwise. Both flags are 0.
- R6: Load-upper (op 3'b100) returns the 16-bit immediate in bits 31:16 and zeros in bits 15:0. Both flags are 0. The operands are ignored.
- R7: Codes 3'b101, 3'b110 and 3'b111 return a zero result with both flags 0.
- R8: A synchronous active-high reset clears `out_valid`, `res`, `ovf_flag` and `cout_flag` to 0.
- R9: Each accepted request yields a response one cycle later. `in_ready` equals !out_valid || out_ready. A response that is not taken keeps its result and flags stable. Responses leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| imm16 | input | 16 | Immediate for load-upper |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| res | output | 32 | Result |
| ovf_flag | output | 1 | Signed overflow for add and subtract |
| cout_flag | output | 1 | Carry out of bit 31 for add and subtract |

## Verification
The embedded assertions check these properties on every cycle:
- the sign rule behind each raised overflow;
- agreement of both comparison outputs with plain signed and unsigned orderings of the current operands;
- the clearing effect of reset;
- the hold and accept rules of the output stream.

Only the bench's scenarios can show the rest:
- the exact result words and carries for boundary operands such as the most negative value and all-ones;
- load-upper placement and the zero response of unused codes;
- correct ordering of responses under random back-pressure.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int IALU_W   = 32;
  localparam int IALU_IMM = 16;
  localparam int IALU_OPW = 3;

  typedef enum logic [IALU_OPW-1:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_LUI  = 3'b100
  } ialu_op_e;
endpackage

// File: rtl/ialu_adder.sv
// Shared adder: the sign slice is kept separate so the carry into it is visible.
module ialu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);
  localparam int LW = W - 1;

  logic [W-1:0] bx;
  logic [LW:0]  low;
  logic         c_sign;

  always_comb begin
    bx        = sub ? ~b : b;
    low       = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{LW{1'b0}}, sub};
    c_sign    = low[LW];
    sum       = {a[W-1] ^ bx[W-1] ^ c_sign, low[LW-1:0]};
    carry_out = (a[W-1] & bx[W-1]) | (c_sign & (a[W-1] ^ bx[W-1]));
    ovf       = c_sign ^ carry_out;
  end

  // R3: a raised overflow implies like-signed addends with a sign flip in the sum
  always_comb begin
    if (ovf === 1'b1)
      a_r3_ovf_sign: assert ((a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]));
  end
endmodule

// File: rtl/ialu_compare.sv
// Less-than flags derived from the subtraction a - b.
module ialu_compare (
  input  logic diff_msb,
  input  logic diff_ovf,
  input  logic diff_cout,
  output logic lt_signed,
  output logic lt_unsigned
);
  always_comb begin
    lt_signed   = diff_msb ^ diff_ovf;
    lt_unsigned = ~diff_cout;
  end
endmodule

// File: rtl/ialu_select.sv
module ialu_select
  import ialu_pkg::*;
#(
  parameter int W   = 32,
  parameter int IMM = 16
) (
  input  logic [IALU_OPW-1:0] op,
  input  logic [W-1:0]        sum,
  input  logic                ovf,
  input  logic                cout,
  input  logic                lt_s,
  input  logic                lt_u,
  input  logic [IMM-1:0]      imm,
  output logic [W-1:0]        res,
  output logic                ovf_o,
  output logic                cout_o
);
  localparam int LOW_W = W - IMM;

  always_comb begin
    res    = '0;
    ovf_o  = 1'b0;
    cout_o = 1'b0;
    case (ialu_op_e'(op))
      OP_ADD, OP_SUB: begin
        res    = sum;
        ovf_o  = ovf;
        cout_o = cout;
      end
      OP_SLT:  res = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: res = {{(W-1){1'b0}}, lt_u};
      OP_LUI:  res = {imm, {LOW_W{1'b0}}};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import ialu_pkg::*;
#(
  parameter int W   = IALU_W,
  parameter int IMM = IALU_IMM
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IALU_OPW-1:0] op_sel,
  input  logic [W-1:0]        opnd_a,
  input  logic [W-1:0]        opnd_b,
  input  logic [IMM-1:0]      imm16,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        res,
  output logic                ovf_flag,
  output logic                cout_flag
);
  logic         do_sub;
  logic [W-1:0] sum;
  logic         add_cout, add_ovf;
  logic         lt_s, lt_u;
  logic [W-1:0] res_d;
  logic         ovf_d, cout_d;
  logic         accept;

  // Compares reuse the subtract path.
  assign do_sub = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);

  ialu_adder #(.W(W)) u_add (
    .a(opnd_a), .b(opnd_b), .sub(do_sub),
    .sum(sum), .carry_out(add_cout), .ovf(add_ovf)
  );

  ialu_compare u_cmp (
    .diff_msb(sum[W-1]), .diff_ovf(add_ovf), .diff_cout(add_cout),
    .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  ialu_select #(.W(W), .IMM(IMM)) u_sel (
    .op(op_sel), .sum(sum), .ovf(add_ovf), .cout(add_cout),
    .lt_s(lt_s), .lt_u(lt_u), .imm(imm16),
    .res(res_d), .ovf_o(ovf_d), .cout_o(cout_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      ovf_flag  <= 1'b0;
      cout_flag <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res       <= res_d;
      ovf_flag  <= ovf_d;
      cout_flag <= cout_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && res == '0 && !ovf_flag && !cout_flag));

  // R9
  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(res) && $stable(ovf_flag) && $stable(cout_flag)));

  // R4: checked against a plain signed ordering while a compare is requested
  a_r4_slt_ref: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SLT) |-> (lt_s == ($signed(opnd_a) < $signed(opnd_b))));

  // R5
  a_r5_ult_ref: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SLTU) |-> (lt_u == (opnd_a < opnd_b)));
endmodule

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    op_sel = 3'd0;
  logic [W-1:0]  opnd_a = '0, opnd_b = '0;
  logic [15:0]   imm16 = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  res;
  logic          ovf_flag, cout_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit rand_ready = 1'b0;

  typedef struct {
    logic [W-1:0] r;
    logic         o;
    logic         c;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  int_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16),
    .out_valid(out_valid), .out_ready(out_ready),
    .res(res), .ovf_flag(ovf_flag), .cout_flag(cout_flag)
  );

  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic [15:0] im);
    exp_t e;
    logic [W:0] s;
    e.r = '0; e.o = 1'b0; e.c = 1'b0;
    case (op)
      3'b000: begin
        s = {1'b0, a} + {1'b0, b};
        e.r = s[W-1:0]; e.c = s[W];
        e.o = (a[W-1] == b[W-1]) && (e.r[W-1] != a[W-1]);
        e.tag = "R1/R3 add";
      end
      3'b001: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e.r = s[W-1:0]; e.c = s[W];
        e.o = (a[W-1] != b[W-1]) && (e.r[W-1] != a[W-1]);
        e.tag = "R2/R3 sub";
      end
      3'b010: begin e.r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; e.tag = "R4 slt"; end
      3'b011: begin e.r = (a < b) ? 32'd1 : 32'd0; e.tag = "R5 sltu"; end
      3'b100: begin e.r = {im, 16'h0000}; e.tag = "R6 lui"; end
      default: e.tag = "R7 unused";
    endcase
    return e;
  endfunction

  // Driver: push expectation, present request until accepted.
  task automatic send(input logic [2:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [15:0] im);
    sb.push_back(model(op, a, b, im));
    op_sel = op; opnd_a = a; opnd_b = b; imm16 = im; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Monitor: compare on transfer, and check stall stability (R9).
  logic [W-1:0] held_r; logic held_o, held_c; bit stalled = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        total++;
        if (!out_valid || res !== held_r || ovf_flag !== held_o || cout_flag !== held_c) begin
          bad++;
          $display("FAIL R9 hold: got v=%b r=%h o=%b c=%b expected v=1 r=%h o=%b c=%b",
                   out_valid, res, ovf_flag, cout_flag, held_r, held_o, held_c);
        end
      end
      stalled = out_valid && !out_ready;
      held_r = res; held_o = ovf_flag; held_c = cout_flag;
      if (out_valid && out_ready) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R9 order: got r=%h with no request expected none", res);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (res !== e.r || ovf_flag !== e.o || cout_flag !== e.c) begin
            bad++;
            $display("FAIL %s: got r=%h o=%b c=%b expected r=%h o=%b c=%b",
                     e.tag, res, ovf_flag, cout_flag, e.r, e.o, e.c);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_ready) out_ready = ($urandom % 3) != 0;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || res !== '0 || ovf_flag !== 1'b0 || cout_flag !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset: got v=%b r=%h o=%b c=%b expected all zero",
               out_valid, res, ovf_flag, cout_flag);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    out_ready = 1'b1;

    send(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);   // R1: -1 + -1 = -2
    send(3'b000, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0);   // R3: pos+pos -> neg
    send(3'b000, 32'h8000_0000, 32'h8000_0000, 16'h0);   // R3: neg+neg -> non-neg
    send(3'b001, 32'h0000_0000, 32'h8000_0000, 16'h0);   // R3: pos-neg -> neg
    send(3'b001, 32'h8000_0000, 32'h0000_0001, 16'h0);   // R3: neg-pos -> pos
    send(3'b001, 32'h0000_0005, 32'h0000_0005, 16'h0);   // R2: zero, carry set
    send(3'b010, 32'h8000_0000, 32'h0000_0001, 16'h0);   // R4: negative smaller
    send(3'b010, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);   // R4: overflowing diff
    send(3'b010, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);   // R4
    send(3'b011, 32'h8000_0000, 32'h0000_0001, 16'h0);   // R5: top bit larger
    send(3'b011, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0);   // R5
    send(3'b100, 32'hDEAD_BEEF, 32'h1234_5678, 16'h007B); // R6: operands ignored
    send(3'b101, 32'h7FFF_FFFF, 32'h0000_0001, 16'hFFFF); // R7
    send(3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF); // R7
    send(3'b111, 32'h8000_0000, 32'h8000_0000, 16'hFFFF); // R7

    // R9: random back-pressure with random traffic
    rand_ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 32'h8000_0000;
      send(3'($urandom % 8), a, b, 16'($urandom));
    end

    rand_ready = 1'b0;
    out_ready = 1'b1;
    repeat (5) @(posedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R9 drain: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule